// File: doc/BRIEF.md
# Synchronizable PWM Gate Timing Unit

This block produces the single gate-drive bit for a boost converter switch. It starts one switching cycle per period. The period comes either from a free-running internal counter or, when a usable external sync pulse train is present, from that train at a 1:1 ratio. Inside a cycle the gate rises one clock after the cycle starts. It falls at the first of three events: the duty-compare flag from the external ramp comparator, an unblanked current-limit flag, or the duty ceiling.

The current-limit flag is masked for a programmable number of clock cycles after each gate rising edge, so that switching spikes do not end a pulse at once. The duty ceiling is derived from whichever period is in use: the internal one, or the last measured sync period. If sync pulses stop, the unit waits two full sync windows and then returns to the internal period. It restarts with a fresh full-length cycle rather than a cut pulse. A low enable kills the gate at once and parks the cycle counter. The sync input is brought through a two-flop synchronizer. The two comparator flags are taken as synchronous to the clock.

Top module: `pwm_sync_gate`

## Requirements
- R1: While reset is asserted the gate output is low. After reset the unit runs from the internal period.
- R2: In internal mode the gate rises once every PERIOD_CYC clock cycles.
- R3: A gate pulse never lasts more than floor(P*MAX_DUTY_PCT/100) cycles, where P is the period in use. Each new cycle begins with at least one low cycle.
- R4: If the duty-compare flag is high during the n-th high cycle of a pulse, the gate is low from cycle n+1 until the next cycle starts.
- R5: The current-limit flag has no effect during the first BLANK_CYC high cycles of a pulse.
- R6: If the current-limit flag is high during high cycle n with n > BLANK_CYC, the gate is low from cycle n+1 for the rest of the cycle.
- R7: A sync pulse qualifies when it is high for SYNC_MIN_W to SYNC_MAX_W clock samples after synchronization. Its falling edge must also come SYNC_MIN_PER to SYNC_MAX_PER cycles after the falling edge of the previous width-qualified pulse. The unit locks on the first pulse that qualifies.
- R8: While locked, each qualified pulse starts exactly one cycle. The gate rises on the fourth rising clock edge after sync goes low. The ceiling uses the measured sync period.
- R9: Pulses that are too narrow, too wide or too closely spaced start no cycle and do not change the internal period.
- R10: While locked, if 2*SYNC_MAX_PER cycles pass with no qualified pulse, the next gate rise comes exactly 2*SYNC_MAX_PER cycles after the previous one. The unit then returns to internal mode, and that pulse may reach the full internal ceiling.
- R11: A low enable forces the gate low in the same cycle and holds the counter at zero. When enable returns, the gate rises after one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | External sync pulse, asynchronous |
| en_i | input | 1 | Run enable, active high |
| duty_done_i | input | 1 | Duty-compare flag: on-time has ended |
| ilim_i | input | 1 | Current-limit comparator flag |
| gate_o | output | 1 | Gate-drive bit |

## Verification
A wrong cycle counter or lock state shows up as a wrong gap between gate rising edges. It is visible one period after the fault, or one sync period after lock should have happened. Faults in the blanking or termination logic change the length of the very next pulse by whole cycles. Timing the pulses is therefore enough to find them. A broken fallback appears as a missing or cut pulse 2*SYNC_MAX_PER cycles after sync stops.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  typedef enum logic {SRC_FREE = 1'b0, SRC_LOCKED = 1'b1} src_mode_e;

  // Longest allowed on-time for a period, in cycles (rounded down).
  function automatic logic [31:0] duty_ceiling(input logic [31:0] period,
                                               input logic [31:0] pct);
    return (period * pct) / 32'd100;
  endfunction

  // Inclusive range test.
  function automatic logic in_window(input logic [31:0] v,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/pwm_sync_qual.sv
module pwm_sync_qual
  import pwm_gate_pkg::*;
#(
  parameter int SYNC_MIN_W   = 10,
  parameter int SYNC_MAX_W   = 790,
  parameter int SYNC_MIN_PER = 333,
  parameter int SYNC_MAX_PER = 847,
  parameter int CW           = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  output logic          accept_o,
  output logic [CW-1:0] gap_o
);
  localparam int WW = $clog2(SYNC_MAX_W + 2);
  localparam logic [WW-1:0] W_SAT = WW'(SYNC_MAX_W + 1);
  localparam logic [CW-1:0] G_SAT = CW'(2 * SYNC_MAX_PER);

  logic          meta_q, samp_q, samp_d;
  logic [WW-1:0] high_cnt;
  logic [CW-1:0] gap_cnt;
  logic          fall_evt, width_ok;

  assign fall_evt = samp_d & ~samp_q;
  assign width_ok = fall_evt &
                    in_window(32'(high_cnt), 32'(SYNC_MIN_W), 32'(SYNC_MAX_W));
  assign accept_o = width_ok &
                    in_window(32'(gap_cnt), 32'(SYNC_MIN_PER), 32'(SYNC_MAX_PER));
  assign gap_o    = gap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q   <= 1'b0;
      samp_q   <= 1'b0;
      samp_d   <= 1'b0;
      high_cnt <= '0;
      gap_cnt  <= G_SAT;
    end else begin
      meta_q <= sync_i;
      samp_q <= meta_q;
      samp_d <= samp_q;
      if (!samp_q)                high_cnt <= '0;
      else if (high_cnt != W_SAT) high_cnt <= high_cnt + 1'b1;
      if (width_ok)               gap_cnt <= CW'(1);
      else if (gap_cnt != G_SAT)  gap_cnt <= gap_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
  import pwm_gate_pkg::*;
#(
  parameter int PERIOD_CYC   = 769,
  parameter int SYNC_MAX_PER = 847,
  parameter int MAX_DUTY_PCT = 98,
  parameter int CW           = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          accept_i,
  input  logic [CW-1:0] gap_i,
  output logic [CW-1:0] cnt_o,
  output logic          cycle_start_o,
  output logic [CW-1:0] on_limit_o,
  output src_mode_e     mode_o
);
  localparam logic [CW-1:0] WRAP_AT  = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] LOST_AT  = CW'(2 * SYNC_MAX_PER - 1);
  localparam logic [CW-1:0] FREE_LIM =
    CW'(duty_ceiling(32'(PERIOD_CYC), 32'(MAX_DUTY_PCT)));

  logic [CW-1:0] cnt_q, lim_q;
  src_mode_e     mode_q;
  logic          wrap, lost;

  assign wrap          = (mode_q == SRC_FREE)   && (cnt_q == WRAP_AT);
  assign lost          = (mode_q == SRC_LOCKED) && (cnt_q == LOST_AT);
  assign cycle_start_o = en_i & (accept_i | wrap | lost);
  assign cnt_o         = cnt_q;
  assign on_limit_o    = lim_q;
  assign mode_o        = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lim_q  <= FREE_LIM;
      mode_q <= SRC_FREE;
    end else if (!en_i) begin
      cnt_q  <= '0;
      lim_q  <= FREE_LIM;
      mode_q <= SRC_FREE;
    end else if (cycle_start_o) begin
      cnt_q <= '0;
      if (accept_i) begin
        mode_q <= SRC_LOCKED;
        lim_q  <= CW'(duty_ceiling(32'(gap_i), 32'(MAX_DUTY_PCT)));
      end else if (lost) begin
        mode_q <= SRC_FREE;
        lim_q  <= FREE_LIM;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_gate_stage.sv
module pwm_gate_stage #(
  parameter int BLANK_CYC = 17,
  parameter int CW        = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          cycle_start_i,
  input  logic [CW-1:0] on_limit_i,
  input  logic          duty_done_i,
  input  logic          ilim_i,
  output logic          gate_o,
  output logic          cut_o
);
  localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYC);

  logic run_q, on_win, blanked;

  assign on_win  = (cnt_i != '0) && (cnt_i <= on_limit_i);
  assign blanked = (cnt_i <= BLANK_END);
  assign cut_o   = on_win & (duty_done_i | (ilim_i & ~blanked));
  assign gate_o  = en_i & run_q & on_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= 1'b1;
    else if (!en_i)         run_q <= 1'b1;
    else if (cycle_start_i) run_q <= 1'b1;
    else if (cut_o)         run_q <= 1'b0;
  end

endmodule

// File: rtl/pwm_sync_gate.sv
module pwm_sync_gate
  import pwm_gate_pkg::*;
#(
  parameter int PERIOD_CYC   = 769,
  parameter int BLANK_CYC    = 17,
  parameter int MAX_DUTY_PCT = 98,
  parameter int SYNC_MIN_W   = 10,
  parameter int SYNC_MAX_W   = 790,
  parameter int SYNC_MIN_PER = 333,
  parameter int SYNC_MAX_PER = 847
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic en_i,
  input  logic duty_done_i,
  input  logic ilim_i,
  output logic gate_o
);
  localparam int CW = $clog2(2 * SYNC_MAX_PER + 1);

  logic          accept;
  logic [CW-1:0] gap;
  logic [CW-1:0] cnt;
  logic          cycle_start;
  logic [CW-1:0] on_limit;
  src_mode_e     mode;
  logic          cut;

  pwm_sync_qual #(
    .SYNC_MIN_W(SYNC_MIN_W), .SYNC_MAX_W(SYNC_MAX_W),
    .SYNC_MIN_PER(SYNC_MIN_PER), .SYNC_MAX_PER(SYNC_MAX_PER), .CW(CW)
  ) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .accept_o(accept), .gap_o(gap)
  );

  pwm_period_timer #(
    .PERIOD_CYC(PERIOD_CYC), .SYNC_MAX_PER(SYNC_MAX_PER),
    .MAX_DUTY_PCT(MAX_DUTY_PCT), .CW(CW)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .accept_i(accept), .gap_i(gap), .cnt_o(cnt),
    .cycle_start_o(cycle_start), .on_limit_o(on_limit), .mode_o(mode)
  );

  pwm_gate_stage #(.BLANK_CYC(BLANK_CYC), .CW(CW)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cnt_i(cnt),
    .cycle_start_i(cycle_start), .on_limit_i(on_limit),
    .duty_done_i(duty_done_i), .ilim_i(ilim_i),
    .gate_o(gate_o), .cut_o(cut)
  );

endmodule

// File: rtl/pwm_sync_gate_chk.sv
module pwm_sync_gate_chk #(
  parameter int BLANK_CYC = 17,
  parameter int CW        = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          duty_done_i,
  input logic          ilim_i,
  input logic          gate_o,
  input logic          cycle_start_i,
  input logic [CW-1:0] on_limit_i
);
  logic [CW:0] hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hcnt_q <= '0;
    else if (gate_o) hcnt_q <= hcnt_q + 1'b1;
    else             hcnt_q <= '0;
  end

  always_comb begin
    if (!rst_ni) AST_RESET_LOW: assert (!gate_o);  // R1
  end

  AST_DUTY_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> (hcnt_q < {1'b0, on_limit_i}));  // R3
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_i |=> !gate_o);  // R3
  AST_DUTY_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && duty_done_i) |=> !gate_o);  // R4
  AST_BLANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && hcnt_q < (CW+1)'(BLANK_CYC) && !duty_done_i && !cycle_start_i &&
     (hcnt_q + 1'b1) < {1'b0, on_limit_i}) |=> (gate_o || !en_i));  // R5
  AST_ILIM_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && ilim_i && hcnt_q >= (CW+1)'(BLANK_CYC)) |=> !gate_o);  // R6
  AST_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !gate_o);  // R11

endmodule

bind pwm_sync_gate pwm_sync_gate_chk #(.BLANK_CYC(BLANK_CYC), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .duty_done_i(duty_done_i),
  .ilim_i(ilim_i), .gate_o(gate_o), .cycle_start_i(cycle_start),
  .on_limit_i(on_limit)
);

// File: tb/pwm_sync_gate_test.sv
module pwm_sync_gate_test;
  localparam int P     = 200;
  localparam int BLANK = 8;
  localparam int MAXP  = 230;

  logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0, en = 1'b1, duty = 1'b0, ilim = 1'b0;
  wire  gate;

  pwm_sync_gate #(
    .PERIOD_CYC(P), .BLANK_CYC(BLANK), .MAX_DUTY_PCT(98),
    .SYNC_MIN_W(4), .SYNC_MAX_W(40), .SYNC_MIN_PER(100), .SYNC_MAX_PER(MAXP)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync_in), .en_i(en),
    .duty_done_i(duty), .ilim_i(ilim), .gate_o(gate)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nvec = 0, nbad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Watchdog: an expired run counts as a miscompare.
  always @(posedge clk) if (cyc > 100000) begin
    nbad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  // Sync pulse generator.
  int sync_on = 0, sync_per = 150, sync_w = 10, sync_ph = 0, sync_fall_cyc = 0;
  always @(negedge clk) begin
    if (sync_on != 0) begin
      logic nxt;
      sync_ph = (sync_ph >= sync_per - 1) ? 0 : sync_ph + 1;
      nxt = (sync_ph < sync_w);
      if (sync_in && !nxt) sync_fall_cyc = cyc;
      sync_in = nxt;
    end else begin
      sync_ph = 0;
      sync_in = 1'b0;
    end
  end

  // Pulse monitor.
  int rise_cnt = 0, fall_cnt = 0, last_rise = 0, prev_rise = 0, rise_delay = 0;
  int hrun = 0, last_len = 0;
  logic gate_prev = 1'b0;
  always @(negedge clk) begin
    if (gate && !gate_prev) begin
      prev_rise  = last_rise;
      last_rise  = cyc;
      rise_delay = cyc - sync_fall_cyc;
      rise_cnt++;
    end
    if (gate) hrun++;
    else if (gate_prev) begin
      last_len = hrun;
      hrun = 0;
      fall_cnt++;
    end
    gate_prev = gate;
  end

  // Drive flags relative to the pulse; returns its length.
  task automatic run_pulse(input int duty_n, input int ilim_n, output int len);
    while (!gate) @(negedge clk);
    len = 0;
    while (gate) begin
      len++;
      duty = (duty_n != 0) && (len >= duty_n);
      ilim = (ilim_n != 0) && (len >= ilim_n);
      @(negedge clk);
    end
    duty = 1'b0;
    ilim = 1'b0;
  endtask

  // {duty-compare cycle, current-limit cycle, expected length}; 0 = never
  localparam int VEC [11][3] = '{
    '{0, 0, 196}, '{50, 0, 50}, '{0, 3, 9}, '{0, 20, 20}, '{30, 12, 12},
    '{5, 40, 5}, '{1, 0, 1}, '{0, 8, 9}, '{0, 9, 9}, '{150, 0, 150},
    '{200, 0, 196}
  };

  initial begin
    int len, k, f, hi;
    repeat (3) @(negedge clk);
    check("R1 gate low in reset", int'(gate), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      run_pulse(VEC[i][0], VEC[i][1], len);
      // R3 R4 R5 R6: pulse length from duty, limit, blanking and ceiling
      check($sformatf("R4/R5/R6/R3 vector %0d", i), len, VEC[i][2]);
    end
    k = rise_cnt;
    wait (rise_cnt >= k + 2); #1;
    check("R2 internal period", last_rise - prev_rise, P);

    // R11 enable
    wait (gate); @(negedge clk);
    en = 1'b0; #1;
    check("R11 gate low at once", int'(gate), 0);
    hi = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (gate) hi++;
    end
    check("R11 held low", hi, 0);
    en = 1'b1;
    @(negedge clk); #1;
    check("R11 restart after one clock", int'(gate), 1);

    // R9 invalid pulses
    sync_per = 150; sync_w = 2; sync_on = 1;
    k = rise_cnt; wait (rise_cnt >= k + 3); #1;
    check("R9 narrow sync ignored", last_rise - prev_rise, P);
    sync_w = 50;
    k = rise_cnt; wait (rise_cnt >= k + 3); #1;
    check("R9 wide sync ignored", last_rise - prev_rise, P);
    sync_per = 80; sync_w = 10;
    k = rise_cnt; wait (rise_cnt >= k + 3); #1;
    check("R9 fast sync ignored", last_rise - prev_rise, P);
    sync_on = 0;

    // R7 R8 lock
    repeat (5) @(negedge clk);
    sync_per = 150; sync_w = 10; sync_on = 1;
    k = rise_cnt; wait (rise_cnt >= k + 4);
    f = fall_cnt; wait (fall_cnt > f); #1;
    check("R7 locked period", last_rise - prev_rise, 150);
    check("R8 rise latency", rise_delay, 4);
    check("R8 ceiling from sync period", last_len, 147);

    // R10 fallback
    k = rise_cnt; wait (rise_cnt > k); #1;
    sync_on = 0;
    wait (rise_cnt > k + 1); #1;
    check("R10 fallback gap", last_rise - prev_rise, 2 * MAXP);
    f = fall_cnt; wait (fall_cnt > f); #1;
    check("R10 full pulse after fallback", last_len, 196);
    wait (rise_cnt > k + 2); #1;
    check("R10 internal period resumes", last_rise - prev_rise, P);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule